// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Pin-Level Emulator

This block is a synthesizable stand-in for an asynchronous fast-page-mode DRAM. It is the partner that a memory controller under test talks to. A fast system clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable) together with the multiplexed address. The block works out the command from the order in which the strobe edges arrive. It keeps a reduced 4-bit-wide array, row by column, and returns read data on a separate output with its own enable, so the controller side sees the same drive and release rules as the real part.

Refresh is tracked alongside the data. There are two ways to refresh a row. A row-strobe-only cycle refreshes the row on the address. A column-before-row cycle refreshes the rows named by an internal counter, one or two rows per cycle. Every row has a coarse age that rises on a prescaled tick. A row whose age reaches the configured limit is reported as stale, and a sticky violation flag records that this happened at least once since reset.

Top module: `dram_emu`

## Requirements
- R1: After synchronous reset, dOutEn and dOut are 0, every row age and the internal refresh counter are 0, anyStale is 0 and refreshViolation is 0.
- R2: A row-strobe fall while the column strobe is high opens a row from addr[ROW_BITS-1:0]. A later column-strobe fall, with write enable high, reads the word at column addr[COL_BITS-1:0]. From the clock after that sample, dOut carries the word, with dOutEn high while output enable is low.
- R3: If write enable is low at the column-strobe fall (early write), dIn is stored at the open row and the addressed column, and dOutEn stays low until the column strobe rises.
- R4: With the row strobe held low, each further column-strobe cycle reads or writes another column of the same row. A rising row strobe closes the row, and column-strobe falls are then ignored.
- R5: Whenever the sampled column strobe is high, dOutEn is 0 and dOut is 0.
- R6: If output enable rises while the column strobe stays low, dOutEn drops. If it falls again with the column strobe still low, the same read word returns.
- R7: A write-enable fall during a read, with the column strobe low and the row open (late write), stores dIn at the open row and column. dOutEn is then held low until the column strobe rises.
- R8: A row-strobe fall while the column strobe is already low is a counter refresh and accesses no data. With ROWS_PER_CBR=2 it refreshes counter rows n and n+1 and advances the counter by 2; with ROWS_PER_CBR=1 it refreshes row n and advances by 1. The counter wraps modulo the row count.
- R9: A row-strobe fall with the column strobe high refreshes only the addressed row.
- R10: A counter refresh made by raising and lowering the row strobe while the column strobe stays low after a read (hidden refresh) keeps the read word on dOut while output enable is low.
- R11: Row ages rise by one every TICK_DIV clocks counted from reset and saturate at AGE_LIMIT. A refresh in the same clock clears the age to 0, and the clear takes priority over the tick. anyStale is high while any age equals AGE_LIMIT, and staleRow gives the lowest such row.
- R12: refreshViolation rises on the clock after anyStale is first seen high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Read data, zero while not driven |
| dOutEn | output | 1 | High when the emulated data pins drive |
| anyStale | output | 1 | Some row has reached the age limit |
| staleRow | output | ROW_BITS | Lowest-numbered stale row |
| refreshViolation | output | 1 | Sticky: a row went stale since reset |

## Verification
The bench drives several strobe patterns:
- Early writes and late writes, which tell the two write orderings apart by where the data lands and by when the outputs release.
- Single reads and page-mode reads across columns of one open row, which separate row latching from column latching.
- Output-enable toggles and column-strobe rises in the middle of a read, which distinguish the release rule from the restore rule.
- A hidden refresh after a read.
- A long run of counter refreshes followed by row-strobe-only refreshes, which shows through staleRow whether one or two rows move per cycle and whether only the addressed row is cleared.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;
  // Per-clock event strobes from control to datapath
  typedef struct packed {
    logic openRow;     // row strobe fell with column strobe high
    logic cbrRefresh;  // row strobe fell with column strobe low
    logic colRead;     // column access, write enable high
    logic colWrite;    // column access, write enable low (early write)
    logic lateWrite;   // write enable fell inside a read access
  } dram_strobe_t;
endpackage

// File: rtl/dram_emu_ctrl.sv
module dram_emu_ctrl
  import dram_emu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         rasN,
  input  logic         casN,
  input  logic         weN,
  input  logic         oeN,
  output dram_strobe_t stb,
  output logic         outEn
);
  logic rasQ, casQ, weQ, oeQ;
  logic rowOpen, readValid, writeLock;
  logic rasFall, rasRise, casFall, casRise, weFall, access;

  always_comb begin
    rasFall = rasQ & ~rasN;
    rasRise = ~rasQ & rasN;
    casFall = casQ & ~casN;
    casRise = ~casQ & casN;
    weFall  = weQ & ~weN;
    access  = casFall & ~rasQ & rowOpen;
    stb.openRow    = rasFall & casN;
    stb.cbrRefresh = rasFall & ~casN;
    stb.colRead    = access & weN;
    stb.colWrite   = access & ~weN;
    stb.lateWrite  = weFall & ~casN & ~casQ & rowOpen & readValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rasQ <= 1'b1; casQ <= 1'b1; weQ <= 1'b1; oeQ <= 1'b1;
      rowOpen <= 1'b0; readValid <= 1'b0; writeLock <= 1'b0;
    end else begin
      rasQ <= rasN; casQ <= casN; weQ <= weN; oeQ <= oeN;
      if (stb.openRow)  rowOpen <= 1'b1;
      else if (rasRise) rowOpen <= 1'b0;
      if (casRise) begin
        readValid <= 1'b0;
        writeLock <= 1'b0;
      end else begin
        if (stb.colRead) readValid <= 1'b1;
        if (stb.colRead) writeLock <= 1'b0;
        else if (stb.colWrite || stb.lateWrite) writeLock <= 1'b1;
      end
    end
  end

  assign outEn = readValid & ~writeLock & ~oeQ;
endmodule

// File: rtl/dram_emu_dp.sv
module dram_emu_dp
  import dram_emu_pkg::*;
#(
  parameter int ROW_BITS     = 6,
  parameter int COL_BITS     = 4,
  parameter int DATA_W       = 4,
  parameter int ADDR_W       = 6,
  parameter int ROWS_PER_CBR = 2,
  parameter int TICK_DIV     = 1024,
  parameter int AGE_LIMIT    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  dram_strobe_t        stb,
  input  logic                outEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dIn,
  output logic [DATA_W-1:0]   dOut,
  output logic                anyStale,
  output logic [ROW_BITS-1:0] staleRow,
  output logic                violation
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int WORDS = ROWS << COL_BITS;
  localparam int AGE_W = $clog2(AGE_LIMIT + 1);
  localparam int PRE_W = $clog2(TICK_DIV);

  logic [DATA_W-1:0]   mem [WORDS];
  logic [ROW_BITS-1:0] rowReg, refCnt, addrRow;
  logic [COL_BITS-1:0] colReg, addrCol;
  logic [DATA_W-1:0]   dHold;
  logic [PRE_W-1:0]    pre;
  logic                tick;
  logic [AGE_W-1:0]    ages [ROWS];
  logic [ROWS-1:0]     rowStale;

  assign addrRow = addr[ROW_BITS-1:0];
  assign addrCol = addr[COL_BITS-1:0];
  assign tick    = (pre == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (stb.colWrite)       mem[{rowReg, addrCol}] <= dIn;
    else if (stb.lateWrite) mem[{rowReg, colReg}]  <= dIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowReg <= '0; colReg <= '0; dHold <= '0; refCnt <= '0; pre <= '0;
      violation <= 1'b0;
    end else begin
      if (stb.openRow) rowReg <= addrRow;
      if (stb.colRead || stb.colWrite) colReg <= addrCol;
      if (stb.colRead) dHold <= mem[{rowReg, addrCol}];
      if (stb.cbrRefresh) refCnt <= refCnt + ROW_BITS'(ROWS_PER_CBR);
      pre <= tick ? '0 : pre + PRE_W'(1);
      if (anyStale) violation <= 1'b1;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit, cbrHit;
    if (ROWS_PER_CBR == 2) begin : g_pair
      assign cbrHit = (refCnt == ROW_BITS'(r)) || ((refCnt + ROW_BITS'(1)) == ROW_BITS'(r));
    end else begin : g_single
      assign cbrHit = (refCnt == ROW_BITS'(r));
    end
    assign hit = (stb.openRow && addrRow == ROW_BITS'(r)) || (stb.cbrRefresh && cbrHit);
    always_ff @(posedge clk) begin
      if (rst || hit) ages[r] <= '0;
      else if (tick && ages[r] != AGE_W'(AGE_LIMIT)) ages[r] <= ages[r] + AGE_W'(1);
    end
    assign rowStale[r] = (ages[r] == AGE_W'(AGE_LIMIT));
  end

  always_comb begin
    staleRow = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (rowStale[i]) staleRow = ROW_BITS'(i);
    end
  end

  assign anyStale = |rowStale;
  assign dOut     = outEn ? dHold : '0;
endmodule

// File: rtl/dram_emu.sv
module dram_emu
  import dram_emu_pkg::*;
#(
  parameter int ROW_BITS     = 6,
  parameter int COL_BITS     = 4,
  parameter int DATA_W       = 4,
  parameter int ADDR_W       = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS,
  parameter int ROWS_PER_CBR = 2,
  parameter int TICK_DIV     = 1024,
  parameter int AGE_LIMIT    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic                oeN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dIn,
  output logic [DATA_W-1:0]   dOut,
  output logic                dOutEn,
  output logic                anyStale,
  output logic [ROW_BITS-1:0] staleRow,
  output logic                refreshViolation
);
  dram_strobe_t stb;

  dram_emu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .stb(stb), .outEn(dOutEn)
  );

  dram_emu_dp #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ROWS_PER_CBR(ROWS_PER_CBR), .TICK_DIV(TICK_DIV), .AGE_LIMIT(AGE_LIMIT)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .outEn(dOutEn), .addr(addr), .dIn(dIn),
    .dOut(dOut), .anyStale(anyStale), .staleRow(staleRow), .violation(refreshViolation)
  );
endmodule

// File: rtl/dram_emu_chk.sv
module dram_emu_chk (
  input logic clk,
  input logic rst,
  input logic casN,
  input logic oeN,
  input logic dOutEn,
  input logic anyStale,
  input logic refreshViolation,
  input logic lateWrite
);
  AST_HIZ_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    dOutEn |-> !$past(casN)); // R5
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    dOutEn |-> !$past(oeN)); // R6
  AST_LATE_WRITE_OFF: assert property (@(posedge clk) disable iff (rst)
    lateWrite |=> !dOutEn); // R7
  AST_VIOL_FOLLOWS_STALE: assert property (@(posedge clk) disable iff (rst)
    anyStale |=> refreshViolation); // R12
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
    refreshViolation |=> refreshViolation); // R12
endmodule

bind dram_emu dram_emu_chk u_chk (
  .clk(clk), .rst(rst), .casN(casN), .oeN(oeN), .dOutEn(dOutEn),
  .anyStale(anyStale), .refreshViolation(refreshViolation), .lateWrite(stb.lateWrite)
);

// File: tb/dram_emu_tb.sv
module dram_emu_tb;
  localparam int RB = 6, CB = 4, DW = 4, AW = 6, PAIR = 2, TDIV = 8, LIM = 10;
  localparam int NROWS = 1 << RB;

  logic clk = 1'b0, rst = 1'b1;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic dOutEn, anyStale, refreshViolation;
  logic [RB-1:0] staleRow;

  always #5 clk = ~clk;

  dram_emu #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .ADDR_W(AW),
    .ROWS_PER_CBR(PAIR), .TICK_DIV(TDIV), .AGE_LIMIT(LIM)) u_dut (
    .clk(clk), .rst(rst), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn), .anyStale(anyStale),
    .staleRow(staleRow), .refreshViolation(refreshViolation));

  int nCmp = 0, nBad = 0;
  string phase = "R1 reset";
  bit started = 0;

  // behavioural reference model
  bit mRas, mCas, mWe, mOe, mOpen, mValid, mLock, mViol;
  int mRow, mCol, mHold, mCnt, mPre;
  int mAge [NROWS];
  int mMem [int];
  bit rf, rr, cf, cr, wf, tk, st;
  int rowIn, colIn;

  function automatic int lowestStale();
    for (int i = 0; i < NROWS; i++) if (mAge[i] == LIM) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      mRas = 1; mCas = 1; mWe = 1; mOe = 1; mOpen = 0; mValid = 0; mLock = 0;
      mViol = 0; mHold = 0; mCnt = 0; mPre = 0;
      for (int i = 0; i < NROWS; i++) mAge[i] = 0;
    end else begin
      rowIn = int'(addr) % NROWS;
      colIn = int'(addr) % (1 << CB);
      rf = mRas && !rasN; rr = !mRas && rasN;
      cf = mCas && !casN; cr = !mCas && casN; wf = mWe && !weN;
      tk = (mPre == TDIV - 1);
      st = (lowestStale() >= 0);
      if (st) mViol = 1;
      for (int i = 0; i < NROWS; i++) if (tk && mAge[i] < LIM) mAge[i]++;
      if (rf && casN) begin mRow = rowIn; mAge[rowIn] = 0; end
      if (rf && !casN) begin
        mAge[mCnt] = 0;
        if (PAIR == 2) mAge[(mCnt + 1) % NROWS] = 0;
        mCnt = (mCnt + PAIR) % NROWS;
      end
      if (cf && !mRas && mOpen) begin
        mCol = colIn;
        if (!weN) begin mMem[mRow * 16 + mCol] = int'(dIn); mLock = 1; end
        else begin mHold = mMem.exists(mRow * 16 + mCol) ? mMem[mRow * 16 + mCol] : 0;
                   mValid = 1; mLock = 0; end
      end else if (wf && !casN && !mCas && mOpen && mValid) begin
        mMem[mRow * 16 + mCol] = int'(dIn); mLock = 1;
      end
      if (cr) begin mValid = 0; mLock = 0; end
      if (rf && casN) mOpen = 1; else if (rr) mOpen = 0;
      mPre = tk ? 0 : mPre + 1;
      mRas = rasN; mCas = casN; mWe = weN; mOe = oeN;
    end
  end

  task automatic check(string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    automatic bit eEn = mValid && !mLock && !mOe;
    automatic int ls = lowestStale();
    check("dOutEn", int'(dOutEn), int'(eEn));
    check("dOut", int'(dOut), eEn ? mHold : 0);
    check("anyStale", int'(anyStale), int'(ls >= 0));
    if (ls >= 0) check("staleRow", int'(staleRow), ls);
    check("refreshViolation", int'(refreshViolation), int'(mViol));
  end

  task automatic drv(input bit r, input bit c, input bit w, input bit o,
                     input int a, input int d);
    @(posedge clk); #1;
    rasN = r; casN = c; weN = w; oeN = o; addr = AW'(a); dIn = DW'(d);
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    hold(2);
    phase = "R3 early write";
    drv(1, 1, 1, 1, 5, 0); drv(0, 1, 1, 1, 5, 0);
    drv(0, 0, 0, 0, 3, 10); drv(0, 0, 1, 0, 3, 0); hold(1);
    phase = "R4 page write";
    drv(0, 1, 1, 1, 0, 0); drv(0, 0, 0, 1, 4, 5); drv(0, 1, 1, 1, 0, 0);
    drv(0, 0, 0, 1, 7, 9); drv(0, 1, 1, 1, 0, 0);
    drv(1, 1, 1, 1, 0, 0); drv(1, 0, 1, 0, 3, 0); drv(1, 1, 1, 1, 0, 0);
    phase = "R2 read";
    drv(0, 1, 1, 1, 5, 0); drv(0, 0, 1, 0, 3, 0); hold(2);
    phase = "R6 oe toggle";
    drv(0, 0, 1, 1, 0, 0); hold(1); drv(0, 0, 1, 0, 0, 0); hold(1);
    phase = "R5 cas high";
    drv(0, 1, 1, 0, 0, 0); hold(1);
    phase = "R4 page read";
    drv(0, 0, 1, 0, 4, 0); drv(0, 1, 1, 0, 0, 0); drv(0, 0, 1, 0, 7, 0);
    drv(0, 1, 1, 0, 0, 0);
    phase = "R7 late write";
    drv(0, 0, 1, 1, 6, 0); drv(0, 0, 0, 1, 6, 12); drv(0, 0, 1, 0, 6, 0); hold(1);
    drv(0, 1, 1, 0, 0, 0); drv(0, 0, 1, 0, 6, 0); hold(1); drv(0, 1, 1, 0, 0, 0);
    phase = "R7 read-modify-write";
    drv(0, 0, 1, 0, 3, 0); drv(0, 0, 0, 0, 3, 11); hold(1); drv(0, 1, 1, 0, 0, 0);
    drv(0, 0, 1, 0, 3, 0); hold(1);
    phase = "R10 hidden refresh";
    drv(1, 0, 1, 0, 0, 0); hold(1); drv(0, 0, 1, 0, 0, 0); hold(2);
    drv(0, 0, 0, 1, 0, 7); hold(1);
    drv(0, 1, 1, 1, 0, 0); drv(1, 1, 1, 1, 0, 0);
    phase = "R11 aging";
    hold(100);
    phase = "R8 cbr";
    for (int k = 0; k < 20; k++) begin
      drv(1, 0, 1, 1, 0, 0); drv(0, 0, 1, 1, 0, 0);
      drv(1, 0, 1, 1, 0, 0); drv(1, 1, 1, 1, 0, 0);
    end
    phase = "R9 ras-only";
    for (int k = 40; k < 64; k += 3) begin
      drv(0, 1, 1, 1, k, 0); drv(1, 1, 1, 1, 0, 0);
    end
    phase = "R12 sticky";
    hold(120);
    for (int k = 0; k < 64; k++) begin
      drv(0, 1, 1, 1, k, 0); drv(1, 1, 1, 1, 0, 0);
    end
    hold(10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #2000000;
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule